// File: doc/BRIEF.md
# Mailbox Request/Response Exchange Engine

This block is a hardware requester that carries out one complete request/response exchange through a data-object mailbox. The mailbox sits behind a simple four-register port made of an address, read and write strobes, write data and combinational read data. A local user starts an exchange by giving a vendor ID, an object type and a request length in bytes. The engine then reads the request dwords from a local buffer and frames them behind a two-dword header. It launches the object, waits for the answer, and stores the response dwords in a local buffer.

The engine owns the recovery path. A busy or failing mailbox, a malformed answer or an exchange that does not finish in time all lead to an abort. An abort that never settles marks the mailbox dead for good. From then on every request is refused at once. The result is reported as a one-cycle done pulse that carries a two-bit result code and the stored response byte count.

Top module: `mbx_xchg`

## Requirements
- R1: After reset, busy_o, done_o and dead_o are low and no register access is made.
- R2: The first access of an exchange reads status (address 1; bit 0 busy, bit 2 error). If busy is set, the result is code 1. If error is set, the result is code 2. In both cases an abort follows and nothing is written to the write mailbox (address 2).
- R3: The first dword written to the write mailbox is {8'h00, type, vendor ID}. The second is the total length in dwords in bits 17:0, where the total is 2 plus the byte count rounded up to whole dwords. The request dwords follow in buffer order.
- R4: A total length above MAX_DW gives code 3 and writes nothing to the write mailbox. A total of exactly MAX_DW is sent as 0 in the length field.
- R5: When the byte count is not a multiple of 4, the bytes of the last request dword above the count are sent as zero. A whole last dword is sent unchanged.
- R6: After the request, a write of control (address 0) with bit 31 set launches it. Status is then polled every POLL_CYC cycles until ready (bit 31) is seen. The error bit, or TIMEOUT_CYC cycles without ready, gives code 2 and an abort.
- R7: Every read of the read mailbox (address 3) is followed by a write of zero to address 3 before the next read of address 3. A read strobe and a write strobe are never high together.
- R8: The first response dword must equal {8'h00, type, vendor ID} of the request. Otherwise the result is code 2 with an abort.
- R9: A response length field of 0 means MAX_DW dwords. Of the dwords after the header, the first min(count, BUF_DW) are stored at buffer addresses 0 upward. The rest are read, acknowledged and dropped. On success rx_bytes_o is 4 times the stored count.
- R10: Before the acknowledge of the last stored dword, status must still show ready, and after the whole response is drained status must show no error. Either failure gives code 2 with an abort.
- R11: An abort writes control with bit 0 set. Status is then polled until busy and error are both clear. If that takes longer than TIMEOUT_CYC, dead_o sets and stays set. Every later start ends with code 2 and no register access.
- R12: A start is taken only when idle. busy_o rises the cycle after it and stays high until the exchange ends, and done_o is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an exchange (taken when idle) |
| vid_i | input | 16 | Vendor ID of the object |
| otype_i | input | 8 | Object type |
| req_bytes_i | input | BYTES_W | Request payload length in bytes |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle end-of-exchange pulse |
| code_o | output | 2 | Result: 0 ok, 1 busy, 2 I/O error, 3 too long |
| rx_bytes_o | output | 21 | Stored response bytes (0 on failure) |
| dead_o | output | 1 | Sticky: abort failed, mailbox unusable |
| req_addr_o | output | 19 | Request buffer dword address |
| req_data_i | input | 32 | Request buffer dword (combinational) |
| rsp_we_o | output | 1 | Response buffer write enable |
| rsp_addr_o | output | $clog2(BUF_DW) | Response buffer dword address |
| rsp_data_o | output | 32 | Response buffer write data |
| reg_addr_o | output | 2 | Mailbox register: 0 control, 1 status, 2 write, 3 read |
| reg_rd_o | output | 1 | Register read strobe |
| reg_wr_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 32 | Register write data |
| reg_rdata_i | input | 32 | Register read data, valid in the strobe cycle |

## Verification
The bench drives a behavioural mailbox that records every write-mailbox dword. It answers with a scripted response after a delay and can be configured as busy, failing, slow, stuck, or dropping ready. Request lengths that are whole dwords and partial dwords separate the padding logic from a plain copy. A length of exactly the maximum separates the zero encoding from a length one dword too long. Responses shorter than the buffer, longer than the buffer and with a zero length field show that storage and flushing follow the length field and not the buffer size. The failure scripts each aim at one recovery branch: busy or error before sending, error while polling, silence, header mismatch, ready lost, late error, and a stuck abort. The stuck abort shows that the dead state refuses work without touching the port.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int LEN_W = 18;          // length field width in header dword 2
  localparam int CNT_W = LEN_W + 1;   // dword counters

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_WMB  = 2'd2;
  localparam logic [1:0] A_RMB  = 2'd3;

  localparam int B_ABORT = 0;
  localparam int B_GO    = 31;
  localparam int B_BUSY  = 0;
  localparam int B_ERR   = 2;
  localparam int B_RDY   = 31;

  typedef enum logic [1:0] {RC_OK, RC_BUSY, RC_IO, RC_INVAL} rc_e;

  typedef enum logic [4:0] {
    S_IDLE, S_CHK, S_HDR1, S_HDR2, S_PAY, S_GO, S_PWAIT, S_POLL,
    S_RH1, S_AH1, S_RH2, S_AH2, S_RD, S_RDY, S_AD, S_FIN,
    S_ABW, S_AWAIT, S_ARD, S_DONE
  } st_e;
endpackage

// File: rtl/mbx_timer.sv
module mbx_timer #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int POLL_CYC    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o,
  output logic expired_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int PW = $clog2(POLL_CYC + 1);

  logic [TW-1:0] tcnt_q;
  logic [PW-1:0] pcnt_q;

  assign tick_o    = run_i && (pcnt_q == PW'(POLL_CYC - 1));
  assign expired_o = (tcnt_q >= TW'(TIMEOUT_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
      pcnt_q <= '0;
    end else if (clear_i) begin
      tcnt_q <= '0;
      pcnt_q <= '0;
    end else if (run_i) begin
      if (!expired_o) tcnt_q <= tcnt_q + TW'(1);
      pcnt_q <= tick_o ? '0 : pcnt_q + PW'(1);
    end
  end
endmodule

// File: rtl/mbx_len.sv
module mbx_len
  import mbx_pkg::*;
#(
  parameter int BYTES_W = 20,
  parameter int MAX_DW  = 1 << 18,
  parameter int BUF_DW  = 8
) (
  input  logic [BYTES_W-1:0] req_bytes_i,
  input  logic [LEN_W-1:0]   rsp_fld_i,
  output logic [CNT_W-1:0]   req_pay_o,
  output logic [LEN_W-1:0]   req_fld_o,
  output logic               req_big_o,
  output logic [CNT_W-1:0]   rsp_pay_o,
  output logic [CNT_W-1:0]   rsp_keep_o,
  output logic               rsp_short_o
);
  logic [CNT_W:0]   tot;
  logic [CNT_W-1:0] rl;

  always_comb begin
    req_pay_o = CNT_W'(req_bytes_i >> 2) + CNT_W'(|req_bytes_i[1:0]);
    tot       = (CNT_W+1)'(req_pay_o) + (CNT_W+1)'(2);
    req_big_o = tot > (CNT_W+1)'(MAX_DW);
    req_fld_o = (tot == (CNT_W+1)'(MAX_DW)) ? '0 : tot[LEN_W-1:0];

    rl          = (rsp_fld_i == '0) ? CNT_W'(MAX_DW) : CNT_W'(rsp_fld_i);
    rsp_short_o = rl < CNT_W'(2);
    rsp_pay_o   = rl - CNT_W'(2);
    rsp_keep_o  = (rsp_pay_o < CNT_W'(BUF_DW)) ? rsp_pay_o : CNT_W'(BUF_DW);
  end
endmodule

// File: rtl/mbx_xchg.sv
module mbx_xchg
  import mbx_pkg::*;
#(
  parameter int BUF_DW      = 8,
  parameter int BYTES_W     = 20,
  parameter int MAX_DW      = 1 << 18,
  parameter int TIMEOUT_CYC = 125_000_000,
  parameter int POLL_CYC    = TIMEOUT_CYC / 128
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [15:0]                 vid_i,
  input  logic [7:0]                  otype_i,
  input  logic [BYTES_W-1:0]          req_bytes_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [1:0]                  code_o,
  output logic [mbx_pkg::CNT_W+1:0]   rx_bytes_o,
  output logic                        dead_o,
  output logic [mbx_pkg::CNT_W-1:0]   req_addr_o,
  input  logic [31:0]                 req_data_i,
  output logic                        rsp_we_o,
  output logic [$clog2(BUF_DW)-1:0]   rsp_addr_o,
  output logic [31:0]                 rsp_data_o,
  output logic [1:0]                  reg_addr_o,
  output logic                        reg_rd_o,
  output logic                        reg_wr_o,
  output logic [31:0]                 reg_wdata_o,
  input  logic [31:0]                 reg_rdata_i
);
  localparam int AW = $clog2(BUF_DW);

  st_e                 st_q;
  rc_e                 rc_q;
  logic [15:0]         vid_q;
  logic [7:0]          typ_q;
  logic [BYTES_W-1:0]  bytes_q;
  logic [CNT_W-1:0]    idx_q, pay_q, rpay_q, keep_q;
  logic                dead_q, done_q;
  logic [1:0]          code_q;
  logic [CNT_W+1:0]    rxb_q;

  logic [CNT_W-1:0] req_pay, rsp_pay, rsp_keep;
  logic [LEN_W-1:0] req_fld;
  logic             req_big, rsp_short;
  logic             t_clr, t_run, t_tick, t_exp;
  logic [31:0]      pay_word;
  logic             last_pay;

  logic st_busy, st_err, st_rdy, hdr_ok;
  assign st_busy = reg_rdata_i[B_BUSY];
  assign st_err  = reg_rdata_i[B_ERR];
  assign st_rdy  = reg_rdata_i[B_RDY];
  assign hdr_ok  = (reg_rdata_i == {8'h00, typ_q, vid_q});

  mbx_len #(.BYTES_W(BYTES_W), .MAX_DW(MAX_DW), .BUF_DW(BUF_DW)) u_len (
    .req_bytes_i(bytes_q), .rsp_fld_i(reg_rdata_i[LEN_W-1:0]),
    .req_pay_o(req_pay), .req_fld_o(req_fld), .req_big_o(req_big),
    .rsp_pay_o(rsp_pay), .rsp_keep_o(rsp_keep), .rsp_short_o(rsp_short)
  );

  mbx_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .POLL_CYC(POLL_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(t_clr), .run_i(t_run),
    .tick_o(t_tick), .expired_o(t_exp)
  );

  // zero-pad bytes above the count in a partial last dword
  assign last_pay = (idx_q == pay_q - CNT_W'(1));
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      if (last_pay && (bytes_q[1:0] != 2'd0) && (b >= int'(bytes_q[1:0])))
        pay_word[8*b +: 8] = 8'h00;
      else
        pay_word[8*b +: 8] = req_data_i[8*b +: 8];
    end
  end

  always_comb begin
    reg_rd_o    = 1'b0;
    reg_wr_o    = 1'b0;
    reg_addr_o  = A_STAT;
    reg_wdata_o = '0;
    t_clr       = (st_q == S_GO) || (st_q == S_ABW);
    t_run       = (st_q == S_PWAIT) || (st_q == S_POLL) ||
                  (st_q == S_AWAIT) || (st_q == S_ARD);
    unique case (st_q)
      S_CHK, S_POLL, S_RDY, S_FIN, S_ARD: reg_rd_o = 1'b1;
      S_HDR1: begin reg_wr_o = 1'b1; reg_addr_o = A_WMB; reg_wdata_o = {8'h00, typ_q, vid_q}; end
      S_HDR2: begin reg_wr_o = 1'b1; reg_addr_o = A_WMB; reg_wdata_o = 32'(req_fld); end
      S_PAY:  begin reg_wr_o = 1'b1; reg_addr_o = A_WMB; reg_wdata_o = pay_word; end
      S_GO:   begin reg_wr_o = 1'b1; reg_addr_o = A_CTRL; reg_wdata_o[B_GO] = 1'b1; end
      S_ABW:  begin reg_wr_o = 1'b1; reg_addr_o = A_CTRL; reg_wdata_o[B_ABORT] = 1'b1; end
      S_RH1, S_RH2, S_RD: begin reg_rd_o = 1'b1; reg_addr_o = A_RMB; end
      S_AH1, S_AH2, S_AD: begin reg_wr_o = 1'b1; reg_addr_o = A_RMB; end
      default: ;
    endcase
  end

  assign req_addr_o = idx_q;
  assign rsp_we_o   = (st_q == S_RD) && (idx_q < keep_q);
  assign rsp_addr_o = idx_q[AW-1:0];
  assign rsp_data_o = reg_rdata_i;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign code_o     = code_q;
  assign rx_bytes_o = rxb_q;
  assign dead_o     = dead_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;   rc_q <= RC_OK;
      vid_q <= '0;      typ_q <= '0;    bytes_q <= '0;
      idx_q <= '0;      pay_q <= '0;    rpay_q <= '0;  keep_q <= '0;
      dead_q <= 1'b0;   done_q <= 1'b0; code_q <= '0;  rxb_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          vid_q <= vid_i; typ_q <= otype_i; bytes_q <= req_bytes_i;
          keep_q <= '0;
          rc_q <= dead_q ? RC_IO : RC_OK;
          st_q <= dead_q ? S_DONE : S_CHK;
        end
        S_CHK: begin
          idx_q <= '0;
          pay_q <= req_pay;
          if (st_busy)      begin rc_q <= RC_BUSY;  st_q <= S_ABW; end
          else if (st_err)  begin rc_q <= RC_IO;    st_q <= S_ABW; end
          else if (req_big) begin rc_q <= RC_INVAL; st_q <= S_ABW; end
          else st_q <= S_HDR1;
        end
        S_HDR1: st_q <= S_HDR2;
        S_HDR2: st_q <= (pay_q == '0) ? S_GO : S_PAY;
        S_PAY: begin
          idx_q <= idx_q + CNT_W'(1);
          if (last_pay) st_q <= S_GO;
        end
        S_GO: st_q <= S_POLL;
        S_PWAIT: if (t_tick) st_q <= S_POLL;
        S_POLL: begin
          if (st_err)      begin rc_q <= RC_IO; st_q <= S_ABW; end
          else if (st_rdy) st_q <= S_RH1;
          else if (t_exp)  begin rc_q <= RC_IO; st_q <= S_ABW; end
          else st_q <= S_PWAIT;
        end
        S_RH1: if (hdr_ok) st_q <= S_AH1;
               else begin rc_q <= RC_IO; st_q <= S_ABW; end
        S_AH1: st_q <= S_RH2;
        S_RH2: begin
          rpay_q <= rsp_pay;
          keep_q <= rsp_keep;
          if (rsp_short) begin rc_q <= RC_IO; st_q <= S_ABW; end
          else st_q <= S_AH2;
        end
        S_AH2: begin
          idx_q <= '0;
          st_q  <= (rpay_q == '0) ? S_FIN : S_RD;
        end
        S_RD: st_q <= (idx_q == keep_q - CNT_W'(1)) ? S_RDY : S_AD;
        S_RDY: if (st_rdy) st_q <= S_AD;
               else begin rc_q <= RC_IO; st_q <= S_ABW; end
        S_AD: begin
          idx_q <= idx_q + CNT_W'(1);
          if (idx_q == rpay_q - CNT_W'(1)) st_q <= S_FIN;
          else st_q <= S_RD;
        end
        S_FIN: begin
          rc_q <= st_err ? RC_IO : RC_OK;
          st_q <= st_err ? S_ABW : S_DONE;
        end
        S_ABW: st_q <= S_AWAIT;
        S_AWAIT: if (t_tick) st_q <= S_ARD;
        S_ARD: begin
          if (!st_busy && !st_err) st_q <= S_DONE;
          else if (t_exp) begin dead_q <= 1'b1; st_q <= S_DONE; end
          else st_q <= S_AWAIT;
        end
        S_DONE: begin
          done_q <= 1'b1;
          code_q <= rc_q;
          rxb_q  <= (rc_q == RC_OK) ? {keep_q, 2'b00} : '0;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_xchg_chk.sv
module mbx_xchg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        dead_o,
  input logic        reg_rd_o,
  input logic        reg_wr_o,
  input logic [1:0]  reg_addr_o,
  input logic [31:0] reg_wdata_o,
  input logic        rsp_we_o
);
  logic rd_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_pend <= 1'b0;
    else if (reg_rd_o && reg_addr_o == 2'd3) rd_pend <= 1'b1;
    else if (reg_wr_o && reg_addr_o == 2'd3) rd_pend <= 1'b0;
    else if (reg_wr_o && reg_addr_o == 2'd0 && reg_wdata_o[0]) rd_pend <= 1'b0;
  end

  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o));
  assert_ack_before_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o && reg_addr_o == 2'd3) |-> !rd_pend);
  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_on_start_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_dead_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> dead_o);
  assert_dead_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> !(reg_rd_o || reg_wr_o));
  assert_store_in_xchg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_we_o |-> busy_o);
endmodule

bind mbx_xchg mbx_xchg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .dead_o(dead_o), .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o),
  .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o), .rsp_we_o(rsp_we_o)
);

// File: tb/mbx_xchg_test.sv
`timescale 1ns/1ps
module mbx_xchg_test;
  localparam int BUF_DW = 4, BYTES_W = 8, MAX_DW = 16, TMO = 300, POLL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0;
  logic [15:0] vid = '0;
  logic [7:0] typ = '0;
  logic [BYTES_W-1:0] nbytes = '0;
  logic busy_o, done_o, dead_o, rsp_we_o, reg_rd_o, reg_wr_o;
  logic [1:0] code_o, reg_addr_o;
  logic [20:0] rx_bytes_o;
  logic [18:0] req_addr_o;
  logic [31:0] req_data_i, rsp_data_o, reg_wdata_o, reg_rdata_i;
  logic [1:0] rsp_addr_o;

  mbx_xchg #(.BUF_DW(BUF_DW), .BYTES_W(BYTES_W), .MAX_DW(MAX_DW),
             .TIMEOUT_CYC(TMO), .POLL_CYC(POLL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vid_i(vid), .otype_i(typ),
    .req_bytes_i(nbytes), .busy_o(busy_o), .done_o(done_o), .code_o(code_o),
    .rx_bytes_o(rx_bytes_o), .dead_o(dead_o), .req_addr_o(req_addr_o),
    .req_data_i(req_data_i), .rsp_we_o(rsp_we_o), .rsp_addr_o(rsp_addr_o),
    .rsp_data_o(rsp_data_o), .reg_addr_o(reg_addr_o), .reg_rd_o(reg_rd_o),
    .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
  );

  // local buffers
  logic [31:0] qmem [16];
  logic [31:0] rmem [4];
  assign req_data_i = qmem[req_addr_o[3:0]];
  always @(posedge clk) if (rsp_we_o) rmem[rsp_addr_o] <= rsp_data_o;

  // mailbox model: config written by the test, state only by the model
  bit cfg_load = 0, cfg_busy = 0, cfg_err = 0, cfg_stuck = 0, cfg_errgo = 0, cfg_errdrain = 0;
  int cfg_delay = 5, cfg_rdycut = 0, tlen = 0;
  logic [31:0] tmpl [32];
  logic [31:0] rbuf [32];
  logic [31:0] wlog [32];
  logic m_busy = 0, m_err = 0;
  int r_hd = 0, r_tl = 0, pops = 0, wcnt = 0, aborts = 0, accs = 0, cd = 0;
  logic rdy_b;

  assign rdy_b = (r_tl > r_hd) && (cfg_rdycut == 0 || pops < cfg_rdycut);
  always_comb begin
    case (reg_addr_o)
      2'd1: reg_rdata_i = {rdy_b, 28'd0, m_err, 1'b0, m_busy};
      2'd3: reg_rdata_i = (r_tl > r_hd) ? rbuf[r_hd[4:0]] : 32'd0;
      default: reg_rdata_i = 32'd0;
    endcase
  end

  always @(posedge clk) begin
    if (cfg_load) begin
      m_busy <= cfg_busy; m_err <= cfg_err; wcnt <= 0; pops <= 0;
      aborts <= 0; accs <= 0; r_hd <= 0; r_tl <= 0; cd <= 0;
    end else begin
      if (reg_rd_o || reg_wr_o) accs <= accs + 1;
      if (cd > 1) cd <= cd - 1;
      else if (cd == 1) begin
        cd <= 0;
        for (int k = 0; k < 32; k++) rbuf[k] <= tmpl[k];
        r_hd <= 0; r_tl <= tlen;
      end
      if (reg_wr_o) begin
        case (reg_addr_o)
          2'd0: begin
            if (reg_wdata_o[31]) begin cd <= cfg_delay; if (cfg_errgo) m_err <= 1'b1; end
            if (reg_wdata_o[0]) begin
              aborts <= aborts + 1; r_hd <= 0; r_tl <= 0; cd <= 0;
              if (!cfg_stuck) begin m_busy <= 1'b0; m_err <= 1'b0; end
            end
          end
          2'd2: begin wlog[wcnt[4:0]] <= reg_wdata_o; wcnt <= wcnt + 1; end
          2'd3: if (r_tl > r_hd) begin
            r_hd <= r_hd + 1; pops <= pops + 1;
            if (cfg_errdrain && r_hd + 1 == r_tl) m_err <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // checking
  int checks = 0, errors = 0, done_cnt = 0;
  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct packed { logic [1:0] code; logic [31:0] nb; logic dead; } exp_t;
  exp_t expq[$];
  string tagq[$];
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (expq.size() == 0) chk(0, "R12 done without request", 1, 0);
      else begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(code_o == e.code, {t, " code"}, 32'(code_o), 32'(e.code));
        chk(32'(rx_bytes_o) == e.nb, {t, " bytes"}, 32'(rx_bytes_o), e.nb);
        chk(dead_o == e.dead, {t, " dead"}, 32'(dead_o), 32'(e.dead));
      end
      done_cnt++;
    end
  end

  task automatic setup(input bit b, input bit e, input bit stuck, input bit egO,
                       input int dly, input int cut, input bit edr);
    @(negedge clk);
    cfg_busy = b; cfg_err = e; cfg_stuck = stuck; cfg_errgo = egO;
    cfg_delay = dly; cfg_rdycut = cut; cfg_errdrain = edr; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic run(input [15:0] v, input [7:0] t, input [7:0] nb,
                     input [1:0] ec, input [31:0] eb, input bit ed, input string tag);
    int n0;
    expq.push_back('{code: ec, nb: eb, dead: ed});
    tagq.push_back(tag);
    n0 = done_cnt;
    @(negedge clk);
    vid = v; typ = t; nbytes = nb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_o === 1'b1, "R12 busy after start", 32'(busy_o), 1);
    wait (done_cnt > n0);
    @(negedge clk);
  endtask

  task automatic rsp_hdr(input [15:0] v, input [7:0] t, input [31:0] len, input int n);
    tmpl[0] = {8'h00, t, v};
    tmpl[1] = len;
    for (int k = 2; k < 32; k++) tmpl[k] = 32'hC000_0000 + 32'(k);
    tlen = n;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) qmem[k] = 32'h1122_3344 + 32'(k) * 32'h0101_0101;
    for (int k = 0; k < 32; k++) tmpl[k] = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !dead_o && !reg_rd_o && !reg_wr_o, "R1 reset state",
        {busy_o, done_o, dead_o, reg_rd_o, reg_wr_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // normal exchange, partial last dword
    rsp_hdr(16'h1234, 8'h05, 5, 5);
    setup(0, 0, 0, 0, 5, 0, 0);
    run(16'h1234, 8'h05, 6, 2'd0, 12, 0, "R9 normal");
    chk(wcnt == 4, "R3 dword count", wcnt, 4);
    chk(wlog[0] == 32'h0005_1234, "R3 header 1", wlog[0], 32'h0005_1234);
    chk(wlog[1] == 32'd4, "R3 header 2", wlog[1], 4);
    chk(wlog[2] == qmem[0], "R3 payload 0", wlog[2], qmem[0]);
    chk(wlog[3] == 32'h0000_3445, "R5 padded last", wlog[3], 32'h0000_3445);
    chk(rmem[2] == 32'hC000_0004, "R9 stored dword", rmem[2], 32'hC000_0004);
    chk(aborts == 0, "R6 no abort on success", aborts, 0);

    // response longer than buffer, whole last dword
    rsp_hdr(16'hBEEF, 8'h22, 8, 8);
    setup(0, 0, 0, 0, 7, 0, 0);
    run(16'hBEEF, 8'h22, 8, 2'd0, 16, 0, "R9 overflow");
    chk(wlog[3] == qmem[1], "R5 whole last dword", wlog[3], qmem[1]);
    chk(pops == 8, "R7 all dwords popped", pops, 8);
    chk(rmem[3] == 32'hC000_0005, "R9 last kept", rmem[3], 32'hC000_0005);

    // header mismatch
    rsp_hdr(16'h1234, 8'h06, 5, 5);
    setup(0, 0, 0, 0, 5, 0, 0);
    run(16'h1234, 8'h05, 4, 2'd2, 0, 0, "R8 mismatch");
    chk(aborts == 1, "R8 abort issued", aborts, 1);

    // busy before sending
    setup(1, 0, 0, 0, 5, 0, 0);
    run(16'h1234, 8'h05, 4, 2'd1, 0, 0, "R2 busy");
    chk(wcnt == 0 && aborts == 1, "R2 busy: no write, abort", {wcnt[15:0], aborts[15:0]}, 32'h0000_0001);

    // error before sending
    setup(0, 1, 0, 0, 5, 0, 0);
    run(16'h1234, 8'h05, 4, 2'd2, 0, 0, "R2 error");
    chk(wcnt == 0, "R2 error: no write", wcnt, 0);

    // one dword too long
    setup(0, 0, 0, 0, 5, 0, 0);
    run(16'h1234, 8'h05, 60, 2'd3, 0, 0, "R4 too long");
    chk(wcnt == 0, "R4 too long: no write", wcnt, 0);

    // exactly the maximum
    rsp_hdr(16'h1234, 8'h05, 2, 2);
    setup(0, 0, 0, 0, 5, 0, 0);
    run(16'h1234, 8'h05, 56, 2'd0, 0, 0, "R4 max length");
    chk(wlog[1] == 32'd0, "R4 max encoded as 0", wlog[1], 0);
    chk(wcnt == 16, "R4 max dword count", wcnt, 16);
    chk(wlog[15] == qmem[13], "R3 last payload", wlog[15], qmem[13]);

    // response length field 0
    rsp_hdr(16'h1234, 8'h05, 0, 16);
    setup(0, 0, 0, 0, 5, 0, 0);
    run(16'h1234, 8'h05, 4, 2'd0, 16, 0, "R9 zero length field");
    chk(pops == 16, "R9 flush to max", pops, 16);

    // never ready
    setup(0, 0, 0, 0, 0, 0, 0);
    run(16'h1234, 8'h05, 4, 2'd2, 0, 0, "R6 timeout");
    chk(aborts == 1, "R6 timeout abort", aborts, 1);

    // error while polling
    setup(0, 0, 0, 1, 50, 0, 0);
    run(16'h1234, 8'h05, 4, 2'd2, 0, 0, "R6 poll error");
    chk(aborts == 1, "R6 poll error abort", aborts, 1);

    // ready lost before last stored ack
    rsp_hdr(16'h1234, 8'h05, 5, 5);
    setup(0, 0, 0, 0, 5, 4, 0);
    run(16'h1234, 8'h05, 4, 2'd2, 0, 0, "R10 ready lost");

    // error raised once drained
    rsp_hdr(16'h1234, 8'h05, 4, 4);
    setup(0, 0, 0, 0, 5, 0, 1);
    run(16'h1234, 8'h05, 4, 2'd2, 0, 0, "R10 late error");

    // stuck abort -> dead, then refused
    setup(1, 0, 1, 0, 5, 0, 0);
    run(16'h1234, 8'h05, 4, 2'd1, 0, 1, "R11 abort stuck");
    setup(0, 0, 0, 0, 5, 0, 0);
    run(16'h1234, 8'h05, 4, 2'd2, 0, 1, "R11 refused when dead");
    chk(accs == 0, "R11 no access when dead", accs, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R12 watchdog expired actual=%0d expected=%0d", done_cnt, expq.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule